// File: doc/BRIEF.md
# Chained Breakpoint Debug Status Unit

This unit watches the debug events of a processor core and turns them into a debug-entry request and a set of sticky occurrence flags. Breakpoints can be chained. In sequential operation a match on breakpoint A arms breakpoint B. A match on the armed breakpoint B then either asks for debug entry at once or starts a trace countdown that counts retired instructions. Software breakpoints request debug entry directly. FIFO freeze events are only recorded.

Every step of the chain leaves its own flag. All flags share one clear rule: a reset, or an exit from debug mode commanded with both the resume and the execute command bits set. The unit also reports the core's operating state as a two-bit mode code. A debugger reads this code to stay in step with the core. Address comparison and the serial scan path are outside the block, which receives match strobes only.

Top module: `dbg_seq_status`

## Requirements
- R1: While `rst_n` is low and after its release, `occ_flags` is 0, `dbg_req` is 0 and `pmode` is 00.
- R2: A `sw_bkpt_hit` strobe makes `dbg_req` high in the next cycle and sets `occ_flags[4]` (software occurrence).
- R3: A `fifo_frz` strobe sets `occ_flags[2]` in the next cycle and raises no `dbg_req`.
- R4: With `seq_en` high, a `bkpt_a_hit` sets `occ_flags[0]` (A-arm) in the next cycle, arms breakpoint B, and raises no `dbg_req`.
- R5: With `seq_en` high, a `bkpt_b_hit` that comes while breakpoint B is not armed is ignored: `occ_flags[1]` stays 0 and `dbg_req` stays 0.
- R6: With `seq_en` high, a `bkpt_b_hit` on an armed breakpoint B sets `occ_flags[1]` (B-arm). If `trace_en` is low, `dbg_req` rises in the next cycle. If `trace_en` is high, the trace counter loads `trace_load`. An `insn_retire` in that same cycle is not counted.
- R7: After loading, each cycle with both `insn_retire` and `trace_en` high lowers the counter by one. A retire with `trace_en` low is not counted. The cycle after the retire that brings the counter to zero, `dbg_req` is high and `occ_flags[3]` (trace occurrence) is set. A load value of 0 gives this result in the cycle after the B match. Once the counter reaches zero, it stops.
- R8: With `seq_en` low, a `bkpt_a_hit` or `bkpt_b_hit` makes `dbg_req` high in the next cycle and leaves `occ_flags[1:0]` unchanged.
- R9: Flags stay set until a clear. A clear is a cycle with `cmd_go`, `cmd_ex` and `cpu_halted` all high. It zeroes every flag, disarms both breakpoints and stops the counter, all in the next cycle. When a clear and a set fall in the same cycle, the clear wins.
- R10: `dbg_req` is high only in the cycle that follows a cycle containing a request cause. With no further cause, it is low again one cycle later.
- R11: One cycle after the inputs change, `pmode` shows 10 when `cpu_halted` is high, otherwise 01 when `cpu_lowpwr` is high, otherwise 00. It never shows 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of all debug logic |
| bkpt_a_hit | input | 1 | Breakpoint A match strobe |
| bkpt_b_hit | input | 1 | Breakpoint B match strobe |
| sw_bkpt_hit | input | 1 | Software breakpoint instruction executed |
| insn_retire | input | 1 | One instruction retired this cycle |
| fifo_frz | input | 1 | FIFO freeze event |
| cpu_halted | input | 1 | Core is in debug state |
| cpu_lowpwr | input | 1 | Core is in stop, doze or wait |
| seq_en | input | 1 | Chain breakpoints A then B |
| trace_en | input | 1 | Trace countdown enable |
| trace_load | input | CNT_W | Countdown start value |
| cmd_go | input | 1 | Resume command bit |
| cmd_ex | input | 1 | Execute command bit |
| dbg_req | output | 1 | Debug-entry request pulse |
| occ_flags | output | 5 | Sticky flags: [0] A-arm, [1] B-arm, [2] freeze, [3] trace, [4] software |
| pmode | output | 2 | Core mode code |

## Verification
Every result arrives one register stage after its cause. Flags, `dbg_req` and `pmode` change at the clock edge that samples the stimulus. The bench therefore drives inputs on the falling edge and reads outputs on the falling edge that follows the next rising edge. For the trace countdown, the result is due one cycle after the N-th counted retire. The bench sweeps every load value of a 4-bit counter and checks that `dbg_req` stays low after each earlier retire and rises after exactly the N-th. It also inserts a retire with `trace_en` low and one in the B-match cycle, and expects neither to be counted.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

   typedef enum logic [1:0] {
      PM_RUN    = 2'b00,
      PM_LOWPWR = 2'b01,
      PM_HALT   = 2'b10,
      PM_RSVD   = 2'b11
   } pmode_e;

   // positions inside the occurrence vector
   localparam int OCC_ARM_A  = 0;
   localparam int OCC_ARM_B  = 1;
   localparam int OCC_FREEZE = 2;
   localparam int OCC_TRACE  = 3;
   localparam int OCC_SOFT   = 4;
   localparam int OCC_NUM    = 5;

endpackage

// File: rtl/dbg_flag_bank.sv
module dbg_flag_bank #(
   parameter int NUM = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic [NUM-1:0] set,
   output logic [NUM-1:0] flags
);

   generate
      if (NUM < 1) begin : g_bad_num
         $error("dbg_flag_bank: NUM must be positive");
      end
      for (genvar i = 0; i < NUM; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flags[i] <= 1'b0;
            else if (clr)
               flags[i] <= 1'b0;      // clear outranks set
            else if (set[i])
               flags[i] <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/dbg_seq_chain.sv
module dbg_seq_chain #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             seq_en,
   input  logic             trace_en,
   input  logic             hit_a,
   input  logic             hit_b,
   input  logic             retire,
   input  logic [CNT_W-1:0] load_val,
   output logic             arm_a_set,
   output logic             arm_b_set,
   output logic             trace_fire,
   output logic             chain_fire
);

   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   logic             armed_a;
   logic             armed_b;
   logic             run;
   logic [CNT_W-1:0] cnt;
   logic             take_b;
   logic             step;
   logic             last_step;
   logic             load_zero;

   assign take_b     = seq_en & hit_b & armed_a & ~armed_b;
   assign step       = run & trace_en & retire;
   assign last_step  = step & (cnt == CNT_ONE);
   assign load_zero  = (load_val == CNT_ZERO);

   assign arm_a_set  = seq_en & hit_a;
   assign arm_b_set  = take_b;
   assign trace_fire = (take_b & trace_en & load_zero) | last_step;
   assign chain_fire = take_b & ~trace_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_a <= 1'b0;
         armed_b <= 1'b0;
         run     <= 1'b0;
         cnt     <= CNT_ZERO;
      end else if (clr) begin
         armed_a <= 1'b0;
         armed_b <= 1'b0;
         run     <= 1'b0;
         cnt     <= CNT_ZERO;
      end else begin
         if (arm_a_set)
            armed_a <= 1'b1;
         if (take_b) begin
            armed_b <= 1'b1;
            if (trace_en && !load_zero) begin
               cnt <= load_val;
               run <= 1'b1;
            end
         end else if (step) begin
            cnt <= cnt - CNT_ONE;
            if (last_step)
               run <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dbg_mode_enc.sv
module dbg_mode_enc
   import dbg_seq_pkg::*;
(
   input  logic   halted,
   input  logic   lowpwr,
   output pmode_e code
);

   always_comb begin
      if (halted)
         code = PM_HALT;
      else if (lowpwr)
         code = PM_LOWPWR;
      else
         code = PM_RUN;
   end

endmodule

// File: rtl/dbg_seq_status.sv
module dbg_seq_status
   import dbg_seq_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit MODE_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bkpt_a_hit,
   input  logic             bkpt_b_hit,
   input  logic             sw_bkpt_hit,
   input  logic             insn_retire,
   input  logic             fifo_frz,
   input  logic             cpu_halted,
   input  logic             cpu_lowpwr,
   input  logic             seq_en,
   input  logic             trace_en,
   input  logic [CNT_W-1:0] trace_load,
   input  logic             cmd_go,
   input  logic             cmd_ex,
   output logic             dbg_req,
   output logic [4:0]       occ_flags,
   output logic [1:0]       pmode
);

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("dbg_seq_status: CNT_W out of range 1..32");
      end
      if (OCC_NUM != 5) begin : g_bad_flags
         $error("dbg_seq_status: flag vector width mismatch");
      end
   endgenerate

   logic               clr;
   logic               arm_a_set;
   logic               arm_b_set;
   logic               trace_fire;
   logic               chain_fire;
   logic               direct_fire;
   logic               req_d;
   logic [OCC_NUM-1:0] flag_set;
   pmode_e             mode_d;

   // exit from debug with resume+execute wipes the history
   assign clr = cmd_go & cmd_ex & cpu_halted;

   dbg_seq_chain #(.CNT_W(CNT_W)) u_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .seq_en     (seq_en),
      .trace_en   (trace_en),
      .hit_a      (bkpt_a_hit),
      .hit_b      (bkpt_b_hit),
      .retire     (insn_retire),
      .load_val   (trace_load),
      .arm_a_set  (arm_a_set),
      .arm_b_set  (arm_b_set),
      .trace_fire (trace_fire),
      .chain_fire (chain_fire)
   );

   assign direct_fire = ~seq_en & (bkpt_a_hit | bkpt_b_hit);
   assign req_d       = direct_fire | chain_fire | trace_fire | sw_bkpt_hit;

   always_comb begin
      flag_set             = '0;
      flag_set[OCC_ARM_A]  = arm_a_set;
      flag_set[OCC_ARM_B]  = arm_b_set;
      flag_set[OCC_FREEZE] = fifo_frz;
      flag_set[OCC_TRACE]  = trace_fire;
      flag_set[OCC_SOFT]   = sw_bkpt_hit;
   end

   dbg_flag_bank #(.NUM(OCC_NUM)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .set   (flag_set),
      .flags (occ_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dbg_req <= 1'b0;
      else
         dbg_req <= req_d;
   end

   dbg_mode_enc u_mode (
      .halted (cpu_halted),
      .lowpwr (cpu_lowpwr),
      .code   (mode_d)
   );

   generate
      if (MODE_REG) begin : g_mode_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pmode <= PM_RUN;
            else
               pmode <= mode_d;
         end
      end else begin : g_mode_comb
         assign pmode = mode_d;
      end
   endgenerate

endmodule

// File: rtl/dbg_seq_status_chk.sv
module dbg_seq_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bkpt_a_hit,
   input logic       bkpt_b_hit,
   input logic       sw_bkpt_hit,
   input logic       fifo_frz,
   input logic       cpu_halted,
   input logic       seq_en,
   input logic       cmd_go,
   input logic       cmd_ex,
   input logic       dbg_req,
   input logic [4:0] occ_flags,
   input logic [1:0] pmode
);

   logic wipe;
   assign wipe = cmd_go & cmd_ex & cpu_halted;

   assert_soft_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_bkpt_hit && !wipe) |=> (dbg_req && occ_flags[4]));

   assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_frz && !wipe) |=> occ_flags[2]);

   assert_b_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_en && !occ_flags[0] && !occ_flags[1]) |=> !occ_flags[1]);

   assert_direct_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_en && (bkpt_a_hit || bkpt_b_hit)) |=> dbg_req);

   assert_direct_noarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_en && !wipe) |=> $stable(occ_flags[1:0]));

   assert_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> (occ_flags == 5'b0));

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wipe |=> ((occ_flags & $past(occ_flags)) == $past(occ_flags)));

   assert_pmode_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pmode != 2'b11);

endmodule

bind dbg_seq_status dbg_seq_status_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bkpt_a_hit  (bkpt_a_hit),
   .bkpt_b_hit  (bkpt_b_hit),
   .sw_bkpt_hit (sw_bkpt_hit),
   .fifo_frz    (fifo_frz),
   .cpu_halted  (cpu_halted),
   .seq_en      (seq_en),
   .cmd_go      (cmd_go),
   .cmd_ex      (cmd_ex),
   .dbg_req     (dbg_req),
   .occ_flags   (occ_flags),
   .pmode       (pmode)
);

// File: tb/dbg_seq_status_test.sv
`timescale 1ns/1ps
module dbg_seq_status_test;

   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bkpt_a_hit = 0, bkpt_b_hit = 0, sw_bkpt_hit = 0;
   logic          insn_retire = 0, fifo_frz = 0;
   logic          cpu_halted = 0, cpu_lowpwr = 0;
   logic          seq_en = 0, trace_en = 0;
   logic [CW-1:0] trace_load = '0;
   logic          cmd_go = 0, cmd_ex = 0;
   logic          dbg_req;
   logic [4:0]    occ_flags;
   logic [1:0]    pmode;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   dbg_seq_status #(.CNT_W(CW), .MODE_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .bkpt_a_hit(bkpt_a_hit), .bkpt_b_hit(bkpt_b_hit),
      .sw_bkpt_hit(sw_bkpt_hit), .insn_retire(insn_retire),
      .fifo_frz(fifo_frz), .cpu_halted(cpu_halted), .cpu_lowpwr(cpu_lowpwr),
      .seq_en(seq_en), .trace_en(trace_en), .trace_load(trace_load),
      .cmd_go(cmd_go), .cmd_ex(cmd_ex),
      .dbg_req(dbg_req), .occ_flags(occ_flags), .pmode(pmode)
   );

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic quiet();
      bkpt_a_hit = 0; bkpt_b_hit = 0; sw_bkpt_hit = 0;
      insn_retire = 0; fifo_frz = 0; cmd_go = 0; cmd_ex = 0;
      cpu_halted = 0; cpu_lowpwr = 0;
   endtask

   task automatic wipe();
      quiet();
      cpu_halted = 1; cmd_go = 1; cmd_ex = 1;
      tick();
      quiet();
      check("R9 wipe", occ_flags, 5'b0);
      tick();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 flags", occ_flags, 0);
      check("R1 req", dbg_req, 0);
      check("R1 pmode", pmode, 0);
      rst_n = 1;
      tick();
      check("R1 flags after release", occ_flags, 0);
      check("R1 req after release", dbg_req, 0);

      // R11 mode sweep
      for (int m = 0; m < 4; m++) begin
         cpu_halted = m[1]; cpu_lowpwr = m[0];
         tick();
         check("R11 pmode", pmode, m[1] ? 2 : (m[0] ? 1 : 0));
      end
      quiet();
      tick();
      check("R11 pmode back to run", pmode, 0);

      // R3 freeze, sticky
      fifo_frz = 1;
      tick();
      fifo_frz = 0;
      check("R3 freeze flag", occ_flags, 5'b00100);
      check("R3 no request", dbg_req, 0);
      repeat (3) tick();
      check("R9 sticky freeze", occ_flags, 5'b00100);
      wipe();

      // R2 / R10 software breakpoint
      sw_bkpt_hit = 1;
      tick();
      sw_bkpt_hit = 0;
      check("R2 request", dbg_req, 1);
      check("R2 soft flag", occ_flags, 5'b10000);
      tick();
      check("R10 pulse ends", dbg_req, 0);
      wipe();

      // R8 non-sequential sweep
      seq_en = 0;
      for (int ab = 1; ab < 4; ab++) begin
         bkpt_a_hit = ab[0]; bkpt_b_hit = ab[1];
         tick();
         quiet();
         check("R8 direct request", dbg_req, 1);
         check("R8 flags untouched", occ_flags, 0);
         tick();
         check("R10 direct pulse ends", dbg_req, 0);
      end

      // R5 unarmed B, R4 A arm, R6 armed B with trace off
      seq_en = 1; trace_en = 0;
      bkpt_b_hit = 1;
      tick();
      quiet();
      check("R5 B ignored flags", occ_flags, 0);
      check("R5 B ignored req", dbg_req, 0);
      bkpt_a_hit = 1;
      tick();
      quiet();
      check("R4 A arm flag", occ_flags, 5'b00001);
      check("R4 no request", dbg_req, 0);
      bkpt_b_hit = 1;
      tick();
      quiet();
      check("R6 B arm flag", occ_flags, 5'b00011);
      check("R6 direct request", dbg_req, 1);
      tick();
      check("R10 chain pulse ends", dbg_req, 0);
      wipe();

      // R7 countdown sweep over every load value
      for (int n = 0; n < (1 << CW); n++) begin
         seq_en = 1; trace_en = 1;
         bkpt_a_hit = 1;
         tick();
         quiet();
         bkpt_b_hit = 1; trace_load = CW'(n); insn_retire = 1;
         tick();
         quiet();
         if (n == 0) begin
            check("R7 zero load request", dbg_req, 1);
            check("R7 zero load flags", occ_flags, 5'b01011);
         end else begin
            check("R6 loaded no request", dbg_req, 0);
            check("R6 loaded flags", occ_flags, 5'b00011);
            trace_en = 0; insn_retire = 1;
            tick();
            quiet();
            trace_en = 1;
            check("R7 retire without trace ignored", dbg_req, 0);
            for (int i = 1; i <= n; i++) begin
               insn_retire = 1;
               tick();
               quiet();
               check("R7 countdown request", dbg_req, (i == n) ? 1 : 0);
               check("R7 countdown trace flag", occ_flags[3], (i == n) ? 1 : 0);
            end
         end
         insn_retire = 1;
         tick();
         quiet();
         check("R7 stopped at zero", dbg_req, 0);
         wipe();
      end

      // R9 clear stops the counter and disarms
      seq_en = 1; trace_en = 1;
      bkpt_a_hit = 1;
      tick();
      quiet();
      bkpt_b_hit = 1; trace_load = CW'(3);
      tick();
      quiet();
      insn_retire = 1;
      tick();
      wipe();
      for (int k = 0; k < 5; k++) begin
         insn_retire = 1;
         tick();
         quiet();
         check("R9 counter stopped by clear", dbg_req, 0);
      end
      check("R9 flags stay clear", occ_flags, 0);
      bkpt_b_hit = 1;
      tick();
      quiet();
      check("R9 B disarmed by clear", occ_flags, 0);

      // R9 clear beats a same-cycle set
      fifo_frz = 1; sw_bkpt_hit = 1;
      cpu_halted = 1; cmd_go = 1; cmd_ex = 1;
      tick();
      quiet();
      check("R9 clear wins", occ_flags, 0);
      // only one command bit: no clear
      fifo_frz = 1;
      tick();
      quiet();
      cpu_halted = 1; cmd_go = 1;
      tick();
      quiet();
      check("R9 partial command keeps flag", occ_flags, 5'b00100);
      wipe();

      finish_run();
   end

endmodule